// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits at the head of an Ethernet receive path and decides, from the first six bytes of each frame, whether the frame should be kept. Bytes arrive one per clock on a valid-qualified stream that marks the first and the last byte of each frame. The six destination-address bytes are compared with a programmed station address and with the all-ones broadcast address. A reflected CRC-32 of the same six bytes is computed on the fly, and its top six bits select one bit of a 64-bit multicast hash table.

A global receive-enable bit gates every decision, and a promiscuous bit accepts every frame. The checks have a fixed priority: promiscuous, station match, broadcast, then the hash lookup if hashing is on. Anything else is rejected. The verdict is a single-cycle pulse in the clock cycle after the sixth byte. A frame that ends before six bytes gets a reject pulse in the cycle after its last byte. Configuration is written through a plain 32-bit register write port. It is copied into the working set at each start of frame, so a frame already in flight is judged by the settings that held when it began.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset both outputs are low and every configuration field is zero, so receive is disabled and a broadcast frame is rejected.
- R2: The control register at offset 0x30C holds receive enable in bit 0. While it is 0, every frame is rejected, even in promiscuous mode.
- R3: Control bit 6 (promiscuous) accepts every complete frame while receive is enabled.
- R4: The station address is held in three 16-bit registers: bytes 0 and 1 at 0x320, bytes 2 and 3 at 0x31C, and bytes 4 and 5 at 0x318, each with the earlier byte in bits 15:8. An exact match of all six bytes accepts the frame.
- R5: A destination of six 0xFF bytes is accepted.
- R6: With control bit 11 (hash enable) set, the hash is a CRC-32 that starts at 0xFFFFFFFF. It processes byte 0 first, each byte LSB first, shifts right and XORs 0xEDB88320 when the bit shifted out differs from the data bit, and has no final inversion. The frame is accepted when the table bit picked by CRC bits 31:26 is set. With bit 11 clear, the table is ignored.
- R7: Hash index bits 5:4 select table word 0 at 0x34C, word 1 at 0x348, word 2 at 0x344 or word 3 at 0x340. Index bits 3:0 select the bit within the 16-bit word.
- R8: A complete frame that matches none of the enabled checks is rejected.
- R9: A frame whose last byte comes before its sixth byte produces exactly one reject pulse, in the cycle after that last byte.
- R10: Each frame yields exactly one decision pulse, in the cycle after its sixth byte. Bytes after the sixth byte, and bytes outside any frame, produce nothing.
- R11: A configuration write made while a frame is being received has no effect on that frame's decision. It applies from the next start of frame.
- R12: A start-of-frame byte in the middle of a frame abandons the partial frame and starts a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | Marks the first byte of a frame |
| rx_last | input | 1 | Marks the last byte of a frame |
| rx_data | input | 8 | Receive byte |
| dec_valid | output | 1 | One-cycle decision pulse |
| dec_accept | output | 1 | Frame accepted, meaningful with dec_valid |

## Verification
The bench targets the hash path hardest. A design that reversed the table word order, indexed from the wrong CRC bits or inverted the final CRC would accept frames whose selected bit is clear, and would reject frames when only the correct bit is set. It also checks the station-address byte pairing, where a design that swapped high and low bytes would fail exact matches. Short frames, frames longer than six bytes, stray bytes outside a frame and a restart in mid-frame are each driven. A design with an off-by-one counter would give a missing, doubled or mistimed pulse. A configuration write in mid-frame checks that a design applying it at once would change the frame's verdict.

// File: rtl/rxaf_pkg.sv
// Package: shared constants, register offsets, configuration type and the
// per-byte hash CRC step used by the destination address filter.
package rxaf_pkg;

    localparam int BYTE_W     = 8;
    localparam int ADDR_BYTES = 6;
    localparam int ADDR_W     = ADDR_BYTES * BYTE_W;
    localparam int REG_W      = 32;
    localparam int OFS_W      = 12;
    localparam int HWORD_W    = 16;
    localparam int STA_WORDS  = ADDR_W / HWORD_W;
    localparam int HASH_WORDS = 4;
    localparam int HASH_BITS  = HASH_WORDS * HWORD_W;
    localparam int IDX_W      = $clog2(HASH_BITS);
    localparam int CRC_W      = 32;

    localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;
    localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFFFFFF;

    // Control register bit positions
    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_PROM_BIT = 6;
    localparam int CTL_HASH_BIT = 11;

    // Register offsets; station word k sits at STA_OFS + 4k (word 2 = bytes 0,1),
    // hash word j sits at HASH_TOP_OFS - 4j.
    localparam logic [OFS_W-1:0] CTL_OFS      = 12'h30C;
    localparam logic [OFS_W-1:0] STA_OFS      = 12'h318;
    localparam logic [OFS_W-1:0] HASH_TOP_OFS = 12'h34C;

    typedef struct packed {
        logic                 rx_en;
        logic                 promisc;
        logic                 hash_en;
        logic [ADDR_W-1:0]    station;
        logic [HASH_BITS-1:0] table_bits;
    } rxaf_cfg_t;

    typedef enum logic [2:0] {
        V_REJECT,
        V_PROMISC,
        V_STATION,
        V_BCAST,
        V_HASH
    } rxaf_verdict_e;

    // One byte of the reflected hash CRC, data LSB first, no final inversion.
    function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] c,
                                                  input logic [BYTE_W-1:0] b);
        logic [CRC_W-1:0] r;
        r = c;
        for (int i = 0; i < BYTE_W; i++) begin
            if (r[0] ^ b[i]) r = (r >> 1) ^ CRC_POLY;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/rxaf_cfg_regs.sv
// Configuration registers: a write-only 32-bit register port updates the live
// fields; the live set is copied into the working set on each start of frame.
// Assumes single-cycle writes; offsets that decode to nothing are ignored.
module rxaf_cfg_regs
    import rxaf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             frame_start,
    output rxaf_cfg_t        active_cfg
);

    logic                 ctl_en_q, ctl_prom_q, ctl_hash_q;
    logic [ADDR_W-1:0]    sta_live;
    logic [HASH_BITS-1:0] hash_live;
    rxaf_cfg_t            live_cfg;
    logic                 unused_wdata;

    assign unused_wdata = ^{wr_data[REG_W-1:HWORD_W], wr_data[HWORD_W-1:CTL_HASH_BIT+1],
                            wr_data[CTL_HASH_BIT-1:CTL_PROM_BIT+1],
                            wr_data[CTL_PROM_BIT-1:CTL_EN_BIT+1]};

    // Control register: enable, promiscuous and hash-enable bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_en_q   <= 1'b0;
            ctl_prom_q <= 1'b0;
            ctl_hash_q <= 1'b0;
        end else if (wr_en && wr_addr == CTL_OFS) begin
            ctl_en_q   <= wr_data[CTL_EN_BIT];
            ctl_prom_q <= wr_data[CTL_PROM_BIT];
            ctl_hash_q <= wr_data[CTL_HASH_BIT];
        end
    end

    genvar k;
    generate
        for (k = 0; k < STA_WORDS; k++) begin : g_sta
            localparam logic [OFS_W-1:0] OFS = STA_OFS + OFS_W'(4 * k);
            logic [HWORD_W-1:0] word_q;
            // Station word k: higher word index holds earlier address bytes
            always_ff @(posedge clk) begin
                if (!rst_n)                        word_q <= '0;
                else if (wr_en && wr_addr == OFS)  word_q <= wr_data[HWORD_W-1:0];
            end
            assign sta_live[HWORD_W*k +: HWORD_W] = word_q;
        end

        for (k = 0; k < HASH_WORDS; k++) begin : g_hash
            localparam logic [OFS_W-1:0] OFS = HASH_TOP_OFS - OFS_W'(4 * k);
            logic [HWORD_W-1:0] word_q;
            // Hash table word k: word 0 at the top offset, descending after
            always_ff @(posedge clk) begin
                if (!rst_n)                        word_q <= '0;
                else if (wr_en && wr_addr == OFS)  word_q <= wr_data[HWORD_W-1:0];
            end
            assign hash_live[HWORD_W*k +: HWORD_W] = word_q;
        end
    endgenerate

    // Gather the live fields into one record
    always_comb begin
        live_cfg.rx_en      = ctl_en_q;
        live_cfg.promisc    = ctl_prom_q;
        live_cfg.hash_en    = ctl_hash_q;
        live_cfg.station    = sta_live;
        live_cfg.table_bits = hash_live;
    end

    // Working copy: frozen for the duration of a frame
    always_ff @(posedge clk) begin
        if (!rst_n)           active_cfg <= '0;
        else if (frame_start) active_cfg <= live_cfg;
    end

endmodule

// File: rtl/rxaf_capture.sv
// Address capture: counts the first ADDR_BYTES bytes of each frame, shifts them
// into an address register and runs the hash CRC alongside. Emits a one-cycle
// pulse when the address is complete, or when the frame ends early.
// Assumes at most one byte per cycle; a start byte always begins a new frame.
module rxaf_capture
    import rxaf_pkg::*;
#(
    parameter int N_BYTES = ADDR_BYTES
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic                      in_sof,
    input  logic                      in_last,
    input  logic [BYTE_W-1:0]         in_data,
    output logic                      frame_start,
    output logic [N_BYTES*BYTE_W-1:0] dest_addr,
    output logic [IDX_W-1:0]          hash_idx,
    output logic                      full_pulse,
    output logic                      short_pulse
);

    localparam int AW    = N_BYTES * BYTE_W;
    localparam int CNT_W = $clog2(N_BYTES + 1);
    localparam logic [CNT_W-1:0] FINAL_CNT = CNT_W'(N_BYTES - 1);

    logic             active_q;
    logic [CNT_W-1:0] cnt_q;
    logic [AW-1:0]    addr_q;
    logic [CRC_W-1:0] crc_q;
    logic             full_q, short_q;
    logic             take_byte;

    assign frame_start = in_valid && in_sof;
    assign take_byte   = frame_start || (in_valid && active_q);

    // Frame tracking: byte count and the completion / early-end pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            full_q   <= 1'b0;
            short_q  <= 1'b0;
        end else begin
            full_q  <= 1'b0;
            short_q <= 1'b0;
            if (frame_start) begin
                cnt_q <= CNT_W'(1);
                if (in_last) begin
                    active_q <= 1'b0;
                    short_q  <= 1'b1;
                end else begin
                    active_q <= 1'b1;
                end
            end else if (in_valid && active_q) begin
                if (cnt_q == FINAL_CNT) begin
                    full_q   <= 1'b1;
                    active_q <= 1'b0;
                end else if (in_last) begin
                    short_q  <= 1'b1;
                    active_q <= 1'b0;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
        end
    end

    // Address shift register and running hash CRC
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            crc_q  <= CRC_SEED;
        end else if (take_byte) begin
            addr_q <= {addr_q[AW-BYTE_W-1:0], in_data};
            crc_q  <= crc_byte(frame_start ? CRC_SEED : crc_q, in_data);
        end
    end

    assign dest_addr   = addr_q;
    assign hash_idx    = crc_q[CRC_W-1 -: IDX_W];
    assign full_pulse  = full_q;
    assign short_pulse = short_q;

endmodule

// File: rtl/rxaf_decide.sv
// Decision stage: applies the prioritised checks to a captured address and
// drives the one-cycle verdict. Purely combinational from registered inputs.
module rxaf_decide
    import rxaf_pkg::*;
(
    input  rxaf_cfg_t         cfg,
    input  logic [ADDR_W-1:0] dest_addr,
    input  logic [IDX_W-1:0]  hash_idx,
    input  logic              full_pulse,
    input  logic              short_pulse,
    output logic              dec_valid,
    output logic              dec_accept
);

    rxaf_verdict_e verdict;
    logic          station_hit, bcast_hit, hash_hit;

    assign station_hit = (dest_addr == cfg.station);
    assign bcast_hit   = &dest_addr;
    assign hash_hit    = cfg.table_bits[hash_idx];

    // Priority chain: promiscuous, station, broadcast, hash, else reject
    always_comb begin
        if (cfg.promisc)                  verdict = V_PROMISC;
        else if (station_hit)             verdict = V_STATION;
        else if (bcast_hit)               verdict = V_BCAST;
        else if (cfg.hash_en && hash_hit) verdict = V_HASH;
        else                              verdict = V_REJECT;
    end

    assign dec_valid  = full_pulse || short_pulse;
    assign dec_accept = full_pulse && cfg.rx_en && (verdict != V_REJECT);

endmodule

// File: rtl/rx_dest_filter.sv
// Top of the receive destination address filter: register port, address
// capture with running hash, and the decision stage.
// Assumes one byte per cycle and a single clock domain.
module rx_dest_filter
    import rxaf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [OFS_W-1:0]  cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic              rx_last,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              dec_valid,
    output logic              dec_accept
);

    rxaf_cfg_t         active_cfg;
    logic              frame_start;
    logic [ADDR_W-1:0] dest_addr;
    logic [IDX_W-1:0]  hash_idx;
    logic              full_pulse, short_pulse;

    rxaf_cfg_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cfg_wr_en),
        .wr_addr     (cfg_addr),
        .wr_data     (cfg_wdata),
        .frame_start (frame_start),
        .active_cfg  (active_cfg)
    );

    rxaf_capture #(.N_BYTES(ADDR_BYTES)) u_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (rx_valid),
        .in_sof      (rx_sof),
        .in_last     (rx_last),
        .in_data     (rx_data),
        .frame_start (frame_start),
        .dest_addr   (dest_addr),
        .hash_idx    (hash_idx),
        .full_pulse  (full_pulse),
        .short_pulse (short_pulse)
    );

    rxaf_decide u_decide (
        .cfg         (active_cfg),
        .dest_addr   (dest_addr),
        .hash_idx    (hash_idx),
        .full_pulse  (full_pulse),
        .short_pulse (short_pulse),
        .dec_valid   (dec_valid),
        .dec_accept  (dec_accept)
    );

endmodule

// File: rtl/rx_dest_filter_chk.sv
// Checker: tracks frame byte counts and the enable/promiscuous bits from the
// ports, and checks the decision pulse timing and gating against them.
module rx_dest_filter_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr_en,
    input logic [11:0] cfg_addr,
    input logic        cfg_en_bit,
    input logic        cfg_prom_bit,
    input logic        rx_valid,
    input logic        rx_sof,
    input logic        rx_last,
    input logic        dec_valid,
    input logic        dec_accept
);

    logic       live_en, live_prom, snap_en, snap_prom;
    logic [2:0] cnt;
    logic       hit6_q, short_q;

    // Shadow of enable/promiscuous, frozen at each start of frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_en <= 1'b0; live_prom <= 1'b0;
            snap_en <= 1'b0; snap_prom <= 1'b0;
        end else begin
            if (cfg_wr_en && cfg_addr == 12'h30C) begin
                live_en   <= cfg_en_bit;
                live_prom <= cfg_prom_bit;
            end
            if (rx_valid && rx_sof) begin
                snap_en   <= live_en;
                snap_prom <= live_prom;
            end
        end
    end

    // Independent byte counter giving the expected pulse cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= 3'd0; hit6_q <= 1'b0; short_q <= 1'b0;
        end else begin
            hit6_q  <= 1'b0;
            short_q <= 1'b0;
            if (rx_valid && rx_sof) begin
                cnt     <= rx_last ? 3'd0 : 3'd1;
                short_q <= rx_last;
            end else if (rx_valid && cnt != 3'd0) begin
                if (cnt == 3'd5) begin
                    hit6_q <= 1'b1; cnt <= 3'd0;
                end else if (rx_last) begin
                    short_q <= 1'b1; cnt <= 3'd0;
                end else begin
                    cnt <= cnt + 3'd1;
                end
            end
        end
    end

    // R2
    en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && !snap_en |-> !dec_accept);

    // R3
    promisc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit6_q && snap_en && snap_prom |-> dec_accept);

    // R9
    short_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        short_q |-> dec_valid && !dec_accept);

    // R10
    pulse_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> hit6_q || short_q);

    // R10
    sixth_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit6_q |-> dec_valid);

endmodule

bind rx_dest_filter rx_dest_filter_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr_en    (cfg_wr_en),
    .cfg_addr     (cfg_addr),
    .cfg_en_bit   (cfg_wdata[0]),
    .cfg_prom_bit (cfg_wdata[6]),
    .rx_valid     (rx_valid),
    .rx_sof       (rx_sof),
    .rx_last      (rx_last),
    .dec_valid    (dec_valid),
    .dec_accept   (dec_accept)
);

// File: tb/rx_dest_filter_test.sv
module rx_dest_filter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_last = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        dec_valid, dec_accept;

    int n_chk = 0;
    int n_bad = 0;

    // Bench mirror of the programmed configuration
    logic        m_en = 0, m_prom = 0, m_hash = 0;
    logic [47:0] m_sta = '0;
    logic [15:0] m_tab [4];

    rx_dest_filter uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_last(rx_last), .rx_data(rx_data), .dec_valid(dec_valid),
        .dec_accept(dec_accept)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input logic [47:0] da);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int k = 0; k < 6; k++) begin
            logic [7:0] b = da[47-8*k -: 8];
            for (int j = 0; j < 8; j++)
                c = (c[0] ^ b[j]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return c;
    endfunction

    function automatic logic ref_accept(input logic [47:0] da, input int len);
        logic [5:0] idx;
        if (len < 6 || !m_en) return 1'b0;
        if (m_prom) return 1'b1;
        if (da == m_sta) return 1'b1;
        if (da == 48'hFFFFFFFFFFFF) return 1'b1;
        if (m_hash) begin
            idx = ref_crc(da)[31:26];
            return m_tab[idx[5:4]][idx[3:0]];
        end
        return 1'b0;
    endfunction

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    function automatic logic [31:0] ctl_word(input logic en, input logic pr, input logic hs);
        logic [31:0] junk = $urandom & ~32'h0000_0841;
        return junk | (32'(hs) << 11) | (32'(pr) << 6) | 32'(en);
    endfunction

    task automatic set_cfg(input logic en, input logic pr, input logic hs);
        wr(12'h30C, ctl_word(en, pr, hs));
        m_en = en; m_prom = pr; m_hash = hs;
    endtask

    task automatic set_station(input logic [47:0] s);
        wr(12'h320, {16'($urandom), s[47:32]});
        wr(12'h31C, {16'($urandom), s[31:16]});
        wr(12'h318, {16'($urandom), s[15:0]});
        m_sta = s;
    endtask

    task automatic set_word(input int j, input logic [15:0] v);
        wr(12'h34C - 12'(4 * j), {16'($urandom), v});
        m_tab[j] = v;
    endtask

    task automatic frame(input logic [47:0] da, input int len, input bit mid_wr,
                         input logic [11:0] ma, input logic [31:0] md,
                         output int npulse, output logic acc, output int at);
        npulse = 0; acc = 1'b0; at = -1;
        for (int i = 0; i < len; i++) begin
            rx_valid = 1'b1; rx_sof = (i == 0); rx_last = (i == len - 1);
            rx_data = (i < 6) ? da[47-8*i -: 8] : 8'($urandom);
            if (mid_wr && i == 2) begin
                cfg_wr_en = 1'b1; cfg_addr = ma; cfg_wdata = md;
            end else begin
                cfg_wr_en = 1'b0;
            end
            @(negedge clk);
            if (dec_valid) begin npulse++; acc = dec_accept; at = i; end
        end
        rx_valid = 1'b0; rx_sof = 1'b0; rx_last = 1'b0; cfg_wr_en = 1'b0;
        @(negedge clk);
        if (dec_valid) begin npulse++; acc = dec_accept; at = len; end
    endtask

    task automatic run_one(input string tag, input logic [47:0] da, input int len);
        int np, at; logic acc; logic exp;
        exp = ref_accept(da, len);
        frame(da, len, 1'b0, '0, '0, np, acc, at);
        check({tag, " R10 pulses"}, np, 1);
        check({tag, " R10 timing"}, at, (len < 6 ? len : 6) - 1);
        check({tag, " verdict"}, acc, exp);
    endtask

    initial begin
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int np, at; logic acc;
        logic [47:0] sta, da, hda;
        logic [5:0] hidx;
        void'($urandom(32'd20240611));
        for (int j = 0; j < 4; j++) m_tab[j] = '0;

        repeat (3) @(negedge clk);
        check("R1 dec_valid in reset", dec_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 dec_valid after reset", dec_valid, 0);
        check("R1 dec_accept after reset", dec_accept, 0);
        run_one("R1 broadcast default cfg", 48'hFFFFFFFFFFFF, 8);

        sta = 48'h0A1B2C3D4E5F;
        set_station(sta);
        set_cfg(1'b0, 1'b1, 1'b1);
        run_one("R2 disabled station", sta, 6);
        run_one("R2 disabled promisc", 48'h123456789ABC, 7);

        set_cfg(1'b1, 1'b1, 1'b0);
        run_one("R3 promisc any", 48'h123456789ABC, 9);
        run_one("R9 short promisc", 48'h123456789ABC, 3);
        run_one("R9 one byte", 48'hFFFFFFFFFFFF, 1);
        run_one("R9 five bytes", sta, 5);

        set_cfg(1'b1, 1'b0, 1'b0);
        run_one("R4 station exact", sta, 6);
        run_one("R4 last byte off", sta ^ 48'h1, 6);
        run_one("R4 first byte off", sta ^ 48'h800000000000, 6);
        run_one("R4 pair swap", 48'h1B0A3D2C5F4E, 6);
        run_one("R5 broadcast", 48'hFFFFFFFFFFFF, 6);
        run_one("R8 near broadcast", 48'hFFFFFFFFFFFE, 6);

        // R6 / R7: hash word order and bit select
        hda = 48'h01005E0000AB;
        hidx = ref_crc(hda)[31:26];
        for (int j = 0; j < 4; j++) set_word(j, 16'hFFFF);
        set_cfg(1'b1, 1'b0, 1'b0);
        run_one("R6 table ignored when hash off", hda, 6);
        set_cfg(1'b1, 1'b0, 1'b1);
        set_word(hidx[5:4], ~(16'h1 << hidx[3:0]));
        run_one("R7 selected bit clear", hda, 6);
        for (int j = 0; j < 4; j++) set_word(j, 16'h0000);
        set_word(hidx[5:4], 16'h1 << hidx[3:0]);
        run_one("R6 selected bit set", hda, 6);
        run_one("R8 other multicast", 48'h01005E0000AC, 6);

        // R10: long frame and stray bytes
        run_one("R10 long frame", 48'hFFFFFFFFFFFF, 12);
        np = 0;
        for (int i = 0; i < 8; i++) begin
            rx_valid = 1'b1; rx_sof = 1'b0; rx_last = (i == 7); rx_data = 8'hFF;
            @(negedge clk);
            if (dec_valid) np++;
        end
        rx_valid = 1'b0; rx_last = 1'b0;
        @(negedge clk);
        if (dec_valid) np++;
        check("R10 stray bytes no pulse", np, 0);

        // R11: mid-frame write to promiscuous has no effect on that frame
        set_cfg(1'b1, 1'b0, 1'b0);
        da = 48'h3344556677AA;
        frame(da, 6, 1'b1, 12'h30C, ctl_word(1'b1, 1'b1, 1'b0), np, acc, at);
        check("R11 write mid-frame ignored", acc, 0);
        m_prom = 1'b1;
        run_one("R11 applied next frame", da, 6);

        // R12: restart mid-frame
        set_cfg(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) begin
            rx_valid = 1'b1; rx_sof = (i == 0); rx_last = 1'b0; rx_data = 8'h55;
            @(negedge clk);
        end
        run_one("R12 restart", 48'hFFFFFFFFFFFF, 6);

        // Random frames against the reference model
        for (int f = 0; f < 400; f++) begin
            int kind, len;
            if (f % 10 == 0) begin
                set_cfg(($urandom % 10) != 0, ($urandom % 5) == 0, $urandom % 2);
                if ($urandom % 3 == 0) set_station({$urandom, 16'($urandom)});
                for (int j = 0; j < 4; j++) set_word(j, 16'($urandom));
            end
            kind = $urandom % 4;
            case (kind)
                0: da = m_sta;
                1: da = 48'hFFFFFFFFFFFF;
                2: da = {$urandom, 16'($urandom)};
                default: da = {8'h01, $urandom, 8'($urandom)};
            endcase
            len = (($urandom % 10) == 0) ? 1 + ($urandom % 5) : 6 + ($urandom % 8);
            run_one("random R8", da, len);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule